// File: doc/BRIEF.md
# Stack Transfer and Call Sequencer

This block carries out the stack side of subroutine linkage for a small CPU core. It owns the stack pointer and the program counter. It accepts one command at a time: save a word on the stack, remove a word from it, call an absolute address, restart to one of eight fixed low-memory vectors, or return. A call or a return may be made conditional on one of eight flag tests. The sequencer moves each 16-bit word over a byte-wide memory port, one byte access per clock.

When a command finishes, the block reports how many processor cycles that command costs. The cost depends on the kind of command and, for a conditional command, on whether it was taken. The core uses this count for its timing bookkeeping. Opcode decode, the ALU and interrupt handling all sit outside this block.

Top module: `stack_call_seq`

## Requirements
- R1: After reset the stack pointer reads 0xFFFF, the program counter reads 0x0000, and busy and done are low.
- R2: A push (cmd_op 0) of cmd_word writes the high byte at SP-1 and then the low byte at SP-2, one write per cycle in that order. It leaves SP lower by 2 and reports 11 cycles.
- R3: A pop (cmd_op 1) reads the byte at SP as the low byte and the byte at SP+1 as the high byte. It presents {high,low} on pop_word, leaves SP higher by 2 and reports 10 cycles.
- R4: A call (cmd_op 2) that is taken pushes the current PC (high byte first, as in R2) and loads cmd_word into PC, reporting 17 cycles. A conditional call that is not taken makes no memory access, changes neither SP nor PC, and reports 10 cycles.
- R5: A return (cmd_op 4) pops a word into PC, using the byte order of R3. An unconditional return reports 10 cycles. A conditional return reports 11 cycles when taken and 5 when not taken, and when not taken it makes no access.
- R6: A restart (cmd_op 3) pushes PC as in R2, loads PC with cmd_vec times 8 (vectors 0x00 to 0x38), and reports 11 cycles.
- R7: With cmd_cond_en set, cmd_cond[2:1] selects the flag bit under test: 0 selects bit 6 (zero), 1 selects bit 0 (carry), 2 selects bit 2 (parity/overflow) and 3 selects bit 7 (sign). The command is taken when that bit equals cmd_cond[0]. No other flag bit has any effect. With cmd_cond_en clear, the command is always taken.
- R8: There is at most one memory access per cycle, and mem_we and mem_re are never high together. Busy stays high from the cycle after acceptance until the command completes. Done pulses for one cycle, with busy low, together with the updated cycles output.
- R9: The stack pointer wraps modulo 2^16 in both directions.
- R10: A command presented while busy is ignored. An op code of 5, 6 or 7 is also ignored: nothing is accessed, no done pulse occurs, and SP and PC are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present, accepted when not busy |
| cmd_op | input | 3 | 0 push, 1 pop, 2 call, 3 restart, 4 return |
| cmd_cond_en | input | 1 | Make call or return conditional |
| cmd_cond | input | 3 | Condition code, see R7 |
| cmd_word | input | 16 | Word to push, or call target |
| cmd_vec | input | 3 | Restart vector index |
| flags | input | 8 | Flag byte tested by conditions |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe, one cycle per byte |
| mem_re | output | 1 | Read strobe; mem_rdata is taken in the same cycle |
| mem_rdata | input | 8 | Read data for the addressed byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 5 | Processor cycle cost of the last completed command |
| pop_word | output | 16 | Word removed by the last pop |
| sp | output | 16 | Stack pointer |
| pc | output | 16 | Program counter |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, 8-bit data, eight vectors spaced 8 apart, and the stack pointer starting at 0xFFFF. Because of that reset value, the very first pop already wraps through address zero, and a following push wraps back. The bench sweeps all eight condition codes against all sixteen combinations of the four tested flag bits. In every combination the untested flag bits hold the opposite values, which covers each taken and not-taken path for both calls and returns. It also walks all eight restart vectors, and it exercises the commands ignored while busy and the undefined op codes.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [2:0] {
      OP_PUSH = 3'd0,
      OP_POP  = 3'd1,
      OP_CALL = 3'd2,
      OP_RST  = 3'd3,
      OP_RET  = 3'd4
   } stk_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_HI,
      ST_WR_LO,
      ST_RD_LO,
      ST_RD_HI,
      ST_SKIP
   } stk_state_e;

   function automatic logic op_legal(input logic [2:0] op);
      return op <= 3'd4;
   endfunction

   function automatic int max_of8(input int a, input int b, input int c, input int d,
                                  input int e, input int f, input int g, input int h);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      if (f > m) m = f;
      if (g > m) m = g;
      if (h > m) m = h;
      return m;
   endfunction
endpackage

// File: rtl/stk_cond_eval.sv
module stk_cond_eval #(
   parameter int FW     = 8,
   parameter int ZF_BIT = 6,
   parameter int CF_BIT = 0,
   parameter int PF_BIT = 2,
   parameter int SF_BIT = 7
) (
   input  logic [FW-1:0] flags,
   input  logic [2:0]    cond,
   output logic          cond_true
);
   localparam int NGRP = 4;
   localparam int POS [NGRP] = '{ZF_BIT, CF_BIT, PF_BIT, SF_BIT};

   logic [NGRP-1:0] sel;

   for (genvar g = 0; g < NGRP; g++) begin : g_pick
      if (POS[g] >= FW || POS[g] < 0) begin : g_bad
         $error("flag position out of range");
      end
      assign sel[g] = flags[POS[g]];
   end

   assign cond_true = (sel[cond[2:1]] == cond[0]);
endmodule

// File: rtl/stk_cost.sv
module stk_cost #(
   parameter int CW            = 5,
   parameter int C_PUSH        = 11,
   parameter int C_POP         = 10,
   parameter int C_CALL        = 17,
   parameter int C_CALL_SKIP   = 10,
   parameter int C_RST         = 11,
   parameter int C_RET         = 10,
   parameter int C_RETC        = 11,
   parameter int C_RETC_SKIP   = 5
) (
   input  logic [2:0]    op,
   input  logic          cond_en,
   input  logic          take,
   output logic [CW-1:0] cost
);
   import stk_pkg::*;

   always_comb begin
      case (op)
         OP_PUSH: cost = CW'(C_PUSH);
         OP_POP:  cost = CW'(C_POP);
         OP_CALL: cost = take ? CW'(C_CALL) : CW'(C_CALL_SKIP);
         OP_RST:  cost = CW'(C_RST);
         OP_RET:  cost = !cond_en ? CW'(C_RET) : (take ? CW'(C_RETC) : CW'(C_RETC_SKIP));
         default: cost = '0;
      endcase
   end
endmodule

// File: rtl/stk_seq_fsm.sv
module stk_seq_fsm #(
   parameter int          AW       = 16,
   parameter int          DW       = 8,
   parameter int          VW       = 3,
   parameter int          CW       = 5,
   parameter int          VEC_STEP = 8,
   parameter logic [AW-1:0] SP_INIT = '1,
   parameter logic [AW-1:0] PC_INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_op,
   input  logic          take,
   input  logic [AW-1:0] cmd_word,
   input  logic [VW-1:0] cmd_vec,
   input  logic [CW-1:0] cost_in,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   output logic          mem_re,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          done,
   output logic [CW-1:0] cycles,
   output logic [AW-1:0] pop_word,
   output logic [AW-1:0] sp,
   output logic [AW-1:0] pc
);
   import stk_pkg::*;

   stk_state_e    state;
   logic [AW-1:0] word_q;
   logic [AW-1:0] tgt_q;
   logic          jump_q;
   logic          ret_q;
   logic [DW-1:0] lo_q;
   logic [CW-1:0] cost_q;
   logic [AW-1:0] sp_dn;
   logic [AW-1:0] sp_up;
   logic          accept;
   logic [AW-1:0] vec_addr;

   assign sp_dn    = sp - 1'b1;
   assign sp_up    = sp + 1'b1;
   assign accept   = (state == ST_IDLE) && cmd_valid && op_legal(cmd_op);
   assign vec_addr = AW'(int'(cmd_vec) * VEC_STEP);
   assign busy     = (state != ST_IDLE);

   always_comb begin
      mem_addr  = sp;
      mem_wdata = '0;
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      case (state)
         ST_WR_HI: begin
            mem_addr  = sp_dn;
            mem_wdata = word_q[AW-1:DW];
            mem_we    = 1'b1;
         end
         ST_WR_LO: begin
            mem_addr  = sp_dn;
            mem_wdata = word_q[DW-1:0];
            mem_we    = 1'b1;
         end
         ST_RD_LO, ST_RD_HI: begin
            mem_addr = sp;
            mem_re   = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         sp       <= SP_INIT;
         pc       <= PC_INIT;
         word_q   <= '0;
         tgt_q    <= '0;
         jump_q   <= 1'b0;
         ret_q    <= 1'b0;
         lo_q     <= '0;
         cost_q   <= '0;
         cycles   <= '0;
         pop_word <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  cost_q <= cost_in;
                  jump_q <= 1'b0;
                  ret_q  <= 1'b0;
                  case (cmd_op)
                     OP_PUSH: begin
                        word_q <= cmd_word;
                        state  <= ST_WR_HI;
                     end
                     OP_POP: state <= ST_RD_LO;
                     OP_CALL: begin
                        if (take) begin
                           word_q <= pc;
                           tgt_q  <= cmd_word;
                           jump_q <= 1'b1;
                           state  <= ST_WR_HI;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end
                     OP_RST: begin
                        word_q <= pc;
                        tgt_q  <= vec_addr;
                        jump_q <= 1'b1;
                        state  <= ST_WR_HI;
                     end
                     default: begin
                        if (take) begin
                           ret_q <= 1'b1;
                           state <= ST_RD_LO;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end
                  endcase
               end
            end
            ST_WR_HI: begin
               sp    <= sp_dn;
               state <= ST_WR_LO;
            end
            ST_WR_LO: begin
               sp <= sp_dn;
               if (jump_q) pc <= tgt_q;
               state  <= ST_IDLE;
               done   <= 1'b1;
               cycles <= cost_q;
            end
            ST_RD_LO: begin
               lo_q  <= mem_rdata;
               sp    <= sp_up;
               state <= ST_RD_HI;
            end
            ST_RD_HI: begin
               sp <= sp_up;
               if (ret_q) pc <= {mem_rdata, lo_q};
               else       pop_word <= {mem_rdata, lo_q};
               state  <= ST_IDLE;
               done   <= 1'b1;
               cycles <= cost_q;
            end
            default: begin
               state  <= ST_IDLE;
               done   <= 1'b1;
               cycles <= cost_q;
            end
         endcase
      end
   end
endmodule

// File: rtl/stack_call_seq.sv
module stack_call_seq #(
   parameter int AW          = 16,
   parameter int DW          = 8,
   parameter int FW          = 8,
   parameter int VEC_COUNT   = 8,
   parameter int VEC_STEP    = 8,
   parameter logic [AW-1:0] SP_INIT = '1,
   parameter logic [AW-1:0] PC_INIT = '0,
   parameter int ZF_BIT      = 6,
   parameter int CF_BIT      = 0,
   parameter int PF_BIT      = 2,
   parameter int SF_BIT      = 7,
   parameter int C_PUSH      = 11,
   parameter int C_POP       = 10,
   parameter int C_CALL      = 17,
   parameter int C_CALL_SKIP = 10,
   parameter int C_RST       = 11,
   parameter int C_RET       = 10,
   parameter int C_RETC      = 11,
   parameter int C_RETC_SKIP = 5,
   localparam int VW   = (VEC_COUNT > 1) ? $clog2(VEC_COUNT) : 1,
   localparam int CMAX = stk_pkg::max_of8(C_PUSH, C_POP, C_CALL, C_CALL_SKIP,
                                          C_RST, C_RET, C_RETC, C_RETC_SKIP),
   localparam int CW   = $clog2(CMAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_op,
   input  logic          cmd_cond_en,
   input  logic [2:0]    cmd_cond,
   input  logic [AW-1:0] cmd_word,
   input  logic [VW-1:0] cmd_vec,
   input  logic [FW-1:0] flags,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   output logic          mem_re,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          done,
   output logic [CW-1:0] cycles,
   output logic [AW-1:0] pop_word,
   output logic [AW-1:0] sp,
   output logic [AW-1:0] pc
);
   if (AW != 2 * DW) begin : g_chk_width
      $error("a stacked word must be exactly two data bytes");
   end
   if ((VEC_COUNT - 1) * VEC_STEP >= (1 << AW)) begin : g_chk_vec
      $error("restart vectors exceed the address space");
   end

   logic          cond_true;
   logic          take;
   logic [CW-1:0] cost;

   stk_cond_eval #(
      .FW(FW), .ZF_BIT(ZF_BIT), .CF_BIT(CF_BIT), .PF_BIT(PF_BIT), .SF_BIT(SF_BIT)
   ) i_cond (
      .flags    (flags),
      .cond     (cmd_cond),
      .cond_true(cond_true)
   );

   assign take = !cmd_cond_en || cond_true;

   stk_cost #(
      .CW(CW), .C_PUSH(C_PUSH), .C_POP(C_POP), .C_CALL(C_CALL),
      .C_CALL_SKIP(C_CALL_SKIP), .C_RST(C_RST), .C_RET(C_RET),
      .C_RETC(C_RETC), .C_RETC_SKIP(C_RETC_SKIP)
   ) i_cost (
      .op     (cmd_op),
      .cond_en(cmd_cond_en),
      .take   (take),
      .cost   (cost)
   );

   stk_seq_fsm #(
      .AW(AW), .DW(DW), .VW(VW), .CW(CW), .VEC_STEP(VEC_STEP),
      .SP_INIT(SP_INIT), .PC_INIT(PC_INIT)
   ) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid),
      .cmd_op   (cmd_op),
      .take     (take),
      .cmd_word (cmd_word),
      .cmd_vec  (cmd_vec),
      .cost_in  (cost),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_we   (mem_we),
      .mem_re   (mem_re),
      .mem_rdata(mem_rdata),
      .busy     (busy),
      .done     (done),
      .cycles   (cycles),
      .pop_word (pop_word),
      .sp       (sp),
      .pc       (pc)
   );
endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          busy,
   input logic          done,
   input logic          mem_we,
   input logic          mem_re,
   input logic [AW-1:0] sp,
   input logic [AW-1:0] pc
);
   assert_one_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_write_lowers_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (sp == AW'($past(sp) - 1'b1)));

   assert_read_raises_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> (sp == AW'($past(sp) + 1'b1)));

   assert_idle_holds_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_valid) |=> ($stable(sp) && $stable(pc)));
endmodule

bind stack_call_seq stk_checker #(.AW(AW)) i_stk_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .busy     (busy),
   .done     (done),
   .mem_we   (mem_we),
   .mem_re   (mem_re),
   .sp       (sp),
   .pc       (pc)
);

// File: tb/test_stack_call_seq.sv
module test_stack_call_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic        cmd_cond_en = 1'b0;
   logic [2:0]  cmd_cond = '0;
   logic [15:0] cmd_word = '0;
   logic [2:0]  cmd_vec = '0;
   logic [7:0]  flags = '0;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we;
   logic        mem_re;
   logic [7:0]  mem_rdata;
   logic        busy;
   logic        done;
   logic [4:0]  cycles;
   logic [15:0] pop_word;
   logic [15:0] sp;
   logic [15:0] pc;

   always #10 clk = ~clk;

   stack_call_seq i_stack_call_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_cond_en(cmd_cond_en), .cmd_cond(cmd_cond), .cmd_word(cmd_word),
      .cmd_vec(cmd_vec), .flags(flags), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy),
      .done(done), .cycles(cycles), .pop_word(pop_word), .sp(sp), .pc(pc)
   );

   logic [7:0]  mem [256];
   int          nw, nr, ndone;
   logic [15:0] wa [4];
   logic [7:0]  wd [4];
   logic [15:0] ra [4];
   int          errors = 0;
   int          checks = 0;
   logic [15:0] exp_sp, exp_pc;

   assign mem_rdata = mem[mem_addr[7:0]];

   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         if (nw < 4) begin
            wa[nw] = mem_addr;
            wd[nw] = mem_wdata;
         end
         nw = nw + 1;
      end
      if (mem_re) begin
         if (nr < 4) ra[nr] = mem_addr;
         nr = nr + 1;
      end
      if (done) ndone = ndone + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic issue(input logic [2:0] op, input logic ce, input logic [2:0] cd,
                        input logic [15:0] w, input logic [2:0] v, input logic [7:0] fl,
                        input bit poke);
      int n;
      @(negedge clk);
      nw = 0; nr = 0;
      cmd_op = op; cmd_cond_en = ce; cmd_cond = cd; cmd_word = w; cmd_vec = v; flags = fl;
      cmd_valid = 1'b1;
      @(negedge clk);
      if (poke) cmd_op = 3'd1;
      else cmd_valid = 1'b0;
      n = 0;
      while (!done && n < 40) begin
         @(negedge clk);
         n++;
         if (n == 1) cmd_valid = 1'b0;
      end
      if (n >= 40) chk(1'b0, "R8", "done never seen", 0, 1);
   endtask

   function automatic bit exp_take(input logic [2:0] cd, input logic [7:0] fl);
      logic b;
      case (cd[2:1])
         2'd0: b = fl[6];
         2'd1: b = fl[0];
         2'd2: b = fl[2];
         default: b = fl[7];
      endcase
      return b == cd[0];
   endfunction

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      nw = 0; nr = 0; ndone = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sp == 16'hFFFF, "R1", "sp after reset", sp, 16'hFFFF);
      chk(pc == 16'h0000, "R1", "pc after reset", pc, 0);
      chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
      rst_n = 1'b1;

      // R3 and R9: pop from 0xFFFF wraps through zero
      mem[8'hFF] = 8'h34;
      mem[8'h00] = 8'h12;
      issue(3'd1, 0, 0, 0, 0, 0, 0);
      chk(pop_word == 16'h1234, "R3", "pop word", pop_word, 16'h1234);
      chk(nr == 2 && ra[0] == 16'hFFFF && ra[1] == 16'h0000, "R9", "pop read addrs",
          {ra[0], ra[1]}, 32'hFFFF0000);
      chk(sp == 16'h0001, "R9", "sp after wrap pop", sp, 1);
      chk(cycles == 10, "R3", "pop cycles", cycles, 10);

      // R2 and R9: push wraps back
      issue(3'd0, 0, 0, 16'hBEEF, 0, 0, 0);
      chk(nw == 2 && wa[0] == 16'h0000 && wd[0] == 8'hBE, "R2", "first write hi",
          {wa[0], wd[0]}, 24'h0000BE);
      chk(wa[1] == 16'hFFFF && wd[1] == 8'hEF, "R9", "second write lo wraps",
          {wa[1], wd[1]}, 24'hFFFFEF);
      chk(sp == 16'hFFFF, "R2", "sp after push", sp, 16'hFFFF);
      chk(cycles == 11, "R2", "push cycles", cycles, 11);
      chk(!busy, "R8", "busy after done", busy, 0);

      // R10: pop presented while push is busy is ignored
      issue(3'd0, 0, 0, 16'h5A3C, 0, 0, 1);
      chk(nr == 0 && nw == 2, "R10", "accesses with busy poke", {nr, nw}, 2);
      chk(sp == 16'hFFFD && cycles == 11, "R10", "sp after busy poke", sp, 16'hFFFD);
      repeat (3) @(negedge clk);
      chk(!busy && sp == 16'hFFFD, "R10", "no late accept", {busy, sp}, 16'hFFFD);
      issue(3'd1, 0, 0, 0, 0, 0, 0);
      chk(pop_word == 16'h5A3C && sp == 16'hFFFF, "R3", "pop back", pop_word, 16'h5A3C);

      // R10: undefined op codes
      for (int u = 5; u < 8; u++) begin
         @(negedge clk);
         nw = 0; nr = 0; ndone = 0;
         cmd_op = 3'(u); cmd_valid = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0;
         repeat (3) @(negedge clk);
         chk(!busy && ndone == 0 && nw == 0 && nr == 0 && sp == 16'hFFFF && pc == 0,
             "R10", "undefined op ignored", {busy, ndone[3:0], sp}, 16'hFFFF);
      end

      exp_sp = 16'hFFFF;
      exp_pc = 16'h0000;

      // R4 and R7: conditional call sweep, then an unconditional return
      for (int cd = 0; cd < 8; cd++) begin
         for (int f4 = 0; f4 < 16; f4++) begin
            logic [7:0]  fl;
            logic [15:0] tgt;
            bit          tk;
            fl = 8'h00;
            fl[6] = f4[0]; fl[0] = f4[1]; fl[2] = f4[2]; fl[7] = f4[3];
            fl[1] = ~f4[0]; fl[3] = ~f4[1]; fl[4] = ~f4[2]; fl[5] = ~f4[3];
            tgt = 16'(cd * 16'h0100 + f4 * 16'h0011 + 16'h2000);
            tk = exp_take(3'(cd), fl);
            issue(3'd2, 1, 3'(cd), tgt, 0, fl, 0);
            if (tk) begin
               chk(pc == tgt && sp == exp_sp - 2 && cycles == 17, "R7", "call taken",
                   {pc, cycles}, {tgt, 5'd17});
               chk(nw == 2 && wd[0] == exp_pc[15:8] && wd[1] == exp_pc[7:0] &&
                   wa[0] == exp_sp - 1, "R4", "call pushes return", {wd[0], wd[1]}, exp_pc);
               issue(3'd4, 0, 0, 0, 0, 0, 0);
               chk(pc == exp_pc && sp == exp_sp && cycles == 10, "R5", "uncond return",
                   {pc, cycles}, {exp_pc, 5'd10});
            end else begin
               chk(pc == exp_pc && sp == exp_sp && cycles == 10 && nw == 0 && nr == 0,
                   "R7", "call not taken", {pc, sp, cycles}, {exp_pc, exp_sp, 5'd10});
            end
         end
      end

      // R5 and R7: conditional return sweep
      for (int cd = 0; cd < 8; cd++) begin
         for (int f4 = 0; f4 < 16; f4++) begin
            logic [7:0]  fl;
            logic [15:0] w;
            bit          tk;
            fl = 8'h00;
            fl[6] = f4[0]; fl[0] = f4[1]; fl[2] = f4[2]; fl[7] = f4[3];
            fl[1] = ~f4[0]; fl[3] = ~f4[1]; fl[4] = ~f4[2]; fl[5] = ~f4[3];
            w = 16'(16'h8000 + cd * 16'h0123 + f4 * 16'h0301);
            tk = exp_take(3'(cd), fl);
            issue(3'd0, 0, 0, w, 0, 0, 0);
            issue(3'd4, 1, 3'(cd), 0, 0, fl, 0);
            if (tk) begin
               chk(pc == w && sp == exp_sp && cycles == 11 && nr == 2, "R5",
                   "cond return taken", {pc, cycles}, {w, 5'd11});
               exp_pc = w;
            end else begin
               chk(pc == exp_pc && sp == exp_sp - 2 && cycles == 5 && nr == 0, "R5",
                   "cond return skipped", {pc, sp, cycles}, {exp_pc, 16'(exp_sp - 2), 5'd5});
               issue(3'd1, 0, 0, 0, 0, 0, 0);
               chk(pop_word == w, "R3", "pop after skip", pop_word, w);
            end
         end
      end

      // R6: every restart vector
      for (int v = 0; v < 8; v++) begin
         issue(3'd3, 0, 0, 0, 3'(v), 0, 0);
         chk(pc == 16'(v * 8) && cycles == 11 && sp == exp_sp - 2, "R6", "restart vector",
             {pc, cycles}, {16'(v * 8), 5'd11});
         chk(nw == 2 && wd[0] == exp_pc[15:8] && wd[1] == exp_pc[7:0], "R6",
             "restart pushes pc", {wd[0], wd[1]}, exp_pc);
         issue(3'd4, 0, 0, 0, 0, 0, 0);
         chk(pc == exp_pc && sp == exp_sp, "R5", "return from restart", pc, exp_pc);
      end

      summary();
      $finish;
   end
endmodule